// File: doc/BRIEF.md
# Printer carriage line counter

This block keeps track of where the paper sits on the current page of a line printer and issues the vertical paper motion that goes with each printed line. A controller gives a print-line pulse together with four spacing request bits: one line before the print, two lines before the print, one line after the print, and skip to the bottom of the page. The block works out how many line feeds the command needs and emits them as single-cycle pulses on consecutive cycles. It then folds the line position back into the page and signals a page overflow to the channel side when the page boundary has been reached or passed.

The page length can be programmed. A new value is taken only when it lies in the allowed window and the block is idle. Taking it returns the line position to the top of the page. While a command is being carried out the block reports busy and ignores both new commands and page-length writes.

Top module: `line_carriage`

## Requirements
- R1: After reset the line position is 0, the page length is LPP_RESET (60), and busy, feed and overflow are all low.
- R2: A page-length write while idle with a value from LPP_MIN (20) to LPP_MAX (100) inclusive loads that value and sets the line position to 0. A value outside that window leaves both page length and line position unchanged. A print-line pulse in the same cycle as an accepted write is dropped.
- R3: The before-print requests add feeds: single-before gives 1, double-before gives 2, and both together give 3.
- R4: The after-print request adds 1 feed to those from the other requests.
- R5: A print-line pulse with none of the four request bits set gives exactly 1 feed.
- R6: With the skip request set, extra feeds are added after the fixed ones until the line position equals the page length. If the fixed feeds already reach or pass the page length, no extra feeds are added.
- R7: After the last feed, if the line position is at or beyond the page length, the page length is subtracted from it and the overflow output pulses for one cycle. Otherwise the position is kept and the overflow output stays low.
- R8: For a command of N feeds, busy rises in the cycle after the accepted print-line pulse and stays high for N+1 cycles. Feed is high in the first N of those cycles, and each feed raises the line position by one.
- R9: While busy, the print-line pulse and page-length writes have no effect. The feed count, line position and page length are those of the command already running.
- R10: The overflow pulse lasts exactly one cycle, appears in the first idle cycle after a command, and is low for as long as a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Page-length write strobe |
| cfg_lines | input | CNT_W (7) | Page-length value offered with cfg_we |
| line_go | input | 1 | Print-line pulse that starts a spacing command |
| sp_before1 | input | 1 | Request one line of feed before the print |
| sp_before2 | input | 1 | Request two lines of feed before the print |
| sp_after | input | 1 | Request one line of feed after the print |
| sp_skip | input | 1 | Request feeds up to the end of the page |
| feed | output | 1 | One line-feed pulse per cycle |
| busy | output | 1 | High while a command is in progress |
| page_ovf | output | 1 | One-cycle page overflow indication |
| line_pos | output | CNT_W (7) | Current line position on the page |
| page_len | output | CNT_W (7) | Programmed page length |

## Verification
On every cycle the assertions check that feed occurs only inside busy and that each feed raises the line position by exactly one. They also check that the overflow pulse is one cycle long, never overlaps busy and always follows a busy period, that the page length stays inside its window and does not move while busy, and that an idle line position is always below the page length. The exact number of feeds for each mix of requests, the skip distance that depends on the current position, the wrapped position after overflow, and the rejection of out-of-window page lengths depend on the command history. Only the bench's scenarios, which compare against counts worked out in advance, can show those.

// File: rtl/lcar_pkg.sv
package lcar_pkg;

   // Spacing request bits that come with a print-line pulse
   typedef struct packed {
      logic before1;
      logic before2;
      logic after1;
      logic skip;
   } space_req_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FEED = 2'd1,
      ST_WRAP = 2'd2
   } seq_state_t;

endpackage

// File: rtl/lcar_page_len.sv
module lcar_page_len #(
   parameter int CNT_W     = 7,
   parameter int LPP_MIN   = 20,
   parameter int LPP_MAX   = 100,
   parameter int LPP_RESET = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             allow,
   output logic             load_ok,
   output logic [CNT_W-1:0] len
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(LPP_MIN);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(LPP_MAX);
   localparam logic [CNT_W-1:0] RST_V = CNT_W'(LPP_RESET);

   logic in_window;

   assign in_window = (wr_val >= MIN_V) && (wr_val <= MAX_V);
   assign load_ok   = wr_en && allow && in_window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len <= RST_V;
      end else if (load_ok) begin
         len <= wr_val;
      end
   end
endmodule

// File: rtl/lcar_feed_plan.sv
module lcar_feed_plan
   import lcar_pkg::*;
#(
   parameter int CNT_W   = 7,
   parameter bit PRE_SUM = 1'b1
) (
   input  space_req_t       req,
   input  logic [CNT_W-1:0] pos,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] total
);
   localparam int SUM_W = CNT_W + 1;

   logic [2:0]       pre_n;
   logic [2:0]       fixed_n;
   logic             no_req;
   logic [SUM_W-1:0] reach;
   logic [SUM_W-1:0] len_w;
   logic [CNT_W-1:0] skip_n;

   // Variant choice for both before-requests at once
   generate
      if (PRE_SUM) begin : g_pre_add
         assign pre_n = {1'b0, req.before2, 1'b0} + {2'b00, req.before1};
      end else begin : g_pre_max
         assign pre_n = req.before2 ? 3'd2 : {2'b00, req.before1};
      end
   endgenerate

   assign no_req  = ~(req.before1 | req.before2 | req.after1 | req.skip);
   assign fixed_n = pre_n + {2'b00, req.after1} + {2'b00, no_req};

   assign reach = {1'b0, pos} + SUM_W'(fixed_n);
   assign len_w = {1'b0, len};

   always_comb begin
      skip_n = '0;
      if (req.skip && (reach < len_w)) begin
         skip_n = CNT_W'(len_w - reach);
      end
   end

   assign total = CNT_W'(fixed_n) + skip_n;
endmodule

// File: rtl/lcar_feed_seq.sv
module lcar_feed_seq
   import lcar_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] total,
   input  logic             load_ok,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             feed,
   output logic             ovf,
   output logic [CNT_W-1:0] pos
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_t       st;
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         left <= '0;
         pos  <= '0;
         ovf  <= 1'b0;
      end else begin
         ovf <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (load_ok) begin
                  pos <= '0;
               end
               if (start) begin
                  left <= total;
                  st   <= ST_FEED;
               end
            end
            ST_FEED: begin
               pos  <= pos + ONE;
               left <= left - ONE;
               if (left == ONE) begin
                  st <= ST_WRAP;
               end
            end
            ST_WRAP: begin
               if (pos >= len) begin
                  pos <= pos - len;
                  ovf <= 1'b1;
               end
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign feed = (st == ST_FEED);
endmodule

// File: rtl/line_carriage.sv
module line_carriage
   import lcar_pkg::*;
#(
   parameter int CNT_W     = 7,
   parameter int LPP_MIN   = 20,
   parameter int LPP_MAX   = 100,
   parameter int LPP_RESET = 60,
   parameter bit PRE_SUM   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_lines,
   input  logic             line_go,
   input  logic             sp_before1,
   input  logic             sp_before2,
   input  logic             sp_after,
   input  logic             sp_skip,
   output logic             feed,
   output logic             busy,
   output logic             page_ovf,
   output logic [CNT_W-1:0] line_pos,
   output logic [CNT_W-1:0] page_len
);
   // Elaboration checks: at most 4 fixed feeds may overshoot the page
   generate
      if (LPP_MIN <= 4) begin : g_bad_min
         $error("LPP_MIN must exceed the largest fixed feed count");
      end
      if (LPP_MIN > LPP_MAX) begin : g_bad_order
         $error("LPP_MIN must not exceed LPP_MAX");
      end
      if (LPP_MAX + 4 >= (1 << CNT_W)) begin : g_bad_width
         $error("CNT_W too narrow for LPP_MAX plus overshoot");
      end
      if ((LPP_RESET < LPP_MIN) || (LPP_RESET > LPP_MAX)) begin : g_bad_rst
         $error("LPP_RESET outside the page-length window");
      end
   endgenerate

   space_req_t       req;
   logic             load_ok;
   logic             start;
   logic [CNT_W-1:0] total;

   assign req   = '{before1: sp_before1, before2: sp_before2,
                    after1: sp_after, skip: sp_skip};
   assign start = line_go && !busy && !load_ok;

   lcar_page_len #(
      .CNT_W    (CNT_W),
      .LPP_MIN  (LPP_MIN),
      .LPP_MAX  (LPP_MAX),
      .LPP_RESET(LPP_RESET)
   ) u_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_val (cfg_lines),
      .allow  (!busy),
      .load_ok(load_ok),
      .len    (page_len)
   );

   lcar_feed_plan #(
      .CNT_W  (CNT_W),
      .PRE_SUM(PRE_SUM)
   ) u_plan (
      .req  (req),
      .pos  (line_pos),
      .len  (page_len),
      .total(total)
   );

   lcar_feed_seq #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .total  (total),
      .load_ok(load_ok),
      .len    (page_len),
      .busy   (busy),
      .feed   (feed),
      .ovf    (page_ovf),
      .pos    (line_pos)
   );
endmodule

// File: rtl/line_carriage_chk.sv
module line_carriage_chk #(
   parameter int CNT_W   = 7,
   parameter int LPP_MIN = 20,
   parameter int LPP_MAX = 100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             feed,
   input logic             busy,
   input logic             page_ovf,
   input logic [CNT_W-1:0] line_pos,
   input logic [CNT_W-1:0] page_len
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(LPP_MIN);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(LPP_MAX);

   p_feed_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      feed |-> busy);

   p_feed_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      feed |=> (line_pos == $past(line_pos) + ONE));

   p_ovf_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      page_ovf |=> !page_ovf);

   p_ovf_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      page_ovf |-> !busy);

   p_ovf_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      page_ovf |-> $past(busy));

   p_idle_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (line_pos < page_len));

   p_len_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (page_len >= MIN_V) && (page_len <= MAX_V));

   p_len_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(page_len));
endmodule

bind line_carriage line_carriage_chk #(
   .CNT_W  (CNT_W),
   .LPP_MIN(LPP_MIN),
   .LPP_MAX(LPP_MAX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .feed    (feed),
   .busy    (busy),
   .page_ovf(page_ovf),
   .line_pos(line_pos),
   .page_len(page_len)
);

// File: tb/tb_line_carriage.sv
module tb_line_carriage;
   localparam int CNT_W = 7;
   localparam int NVEC  = 22;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [CNT_W-1:0] cfg_lines = '0;
   logic             line_go = 1'b0;
   logic             sp_before1 = 1'b0;
   logic             sp_before2 = 1'b0;
   logic             sp_after = 1'b0;
   logic             sp_skip = 1'b0;
   logic             feed, busy, page_ovf;
   logic [CNT_W-1:0] line_pos, page_len;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   line_carriage dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lines(cfg_lines),
      .line_go(line_go), .sp_before1(sp_before1), .sp_before2(sp_before2),
      .sp_after(sp_after), .sp_skip(sp_skip), .feed(feed), .busy(busy),
      .page_ovf(page_ovf), .line_pos(line_pos), .page_len(page_len)
   );

   // {before1,before2,after,skip}, feeds, final position, overflow
   // Page length 20, starting at line 0
   localparam logic [19:0] VEC [NVEC] = '{
      {4'b0000, 8'd1,  7'd1,  1'b0},
      {4'b1000, 8'd1,  7'd2,  1'b0},
      {4'b0100, 8'd2,  7'd4,  1'b0},
      {4'b1100, 8'd3,  7'd7,  1'b0},
      {4'b0010, 8'd1,  7'd8,  1'b0},
      {4'b0110, 8'd3,  7'd11, 1'b0},
      {4'b1110, 8'd4,  7'd15, 1'b0},
      {4'b0001, 8'd5,  7'd0,  1'b1},
      {4'b0110, 8'd3,  7'd3,  1'b0},
      {4'b0011, 8'd17, 7'd0,  1'b1},
      {4'b1110, 8'd4,  7'd4,  1'b0},
      {4'b1110, 8'd4,  7'd8,  1'b0},
      {4'b1110, 8'd4,  7'd12, 1'b0},
      {4'b1110, 8'd4,  7'd16, 1'b0},
      {4'b0100, 8'd2,  7'd18, 1'b0},
      {4'b1100, 8'd3,  7'd1,  1'b1},
      {4'b1110, 8'd4,  7'd5,  1'b0},
      {4'b1110, 8'd4,  7'd9,  1'b0},
      {4'b1110, 8'd4,  7'd13, 1'b0},
      {4'b1110, 8'd4,  7'd17, 1'b0},
      {4'b0100, 8'd2,  7'd19, 1'b0},
      {4'b0101, 8'd2,  7'd1,  1'b1}
   };

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] rq);
      if (rq[0])            return "R6";
      else if (rq == 4'b0)  return "R5";
      else if (rq[1])       return "R4";
      else                  return "R3";
   endfunction

   task automatic write_len(input int val);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_lines = CNT_W'(val);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic run_cmd(input logic [3:0] rq, input int exp_n,
                          input int exp_pos, input bit exp_ovf,
                          input bit disturb);
      int n   = 0;
      int cyc = 0;
      @(negedge clk);
      {sp_before1, sp_before2, sp_after, sp_skip} = rq;
      line_go = 1'b1;
      @(negedge clk);
      line_go = 1'b0;
      {sp_before1, sp_before2, sp_after, sp_skip} = 4'b0;
      chk(busy == 1'b1, "R8", "busy after go", int'(busy), 1);
      while (busy && cyc < 1000) begin
         if (feed) n++;
         cyc++;
         if (disturb && cyc == 3) begin
            line_go = 1'b1; sp_before1 = 1'b1;
            cfg_we = 1'b1;  cfg_lines = CNT_W'(50);
         end else begin
            line_go = 1'b0; sp_before1 = 1'b0; cfg_we = 1'b0;
         end
         @(negedge clk);
      end
      line_go = 1'b0; sp_before1 = 1'b0; cfg_we = 1'b0;
      chk(n == exp_n, tag_of(rq), "feed count", n, exp_n);
      chk(cyc == exp_n + 1, "R8", "busy cycles", cyc, exp_n + 1);
      chk(int'(line_pos) == exp_pos, "R7", "line position", int'(line_pos), exp_pos);
      chk(page_ovf == exp_ovf, "R7", "overflow", int'(page_ovf), int'(exp_ovf));
      @(negedge clk);
      chk(page_ovf == 1'b0 && feed == 1'b0, "R10", "overflow one cycle",
          int'(page_ovf), 0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(line_pos == 0, "R1", "reset position", int'(line_pos), 0);
      chk(page_len == 60, "R1", "reset page length", int'(page_len), 60);
      chk(busy == 0 && feed == 0 && page_ovf == 0, "R1", "reset outputs",
          int'({busy, feed, page_ovf}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(page_len == 60, "R1", "page length after release", int'(page_len), 60);

      // R2: out-of-window values ignored, then lower edge accepted
      write_len(19);
      chk(page_len == 60, "R2", "19 rejected", int'(page_len), 60);
      write_len(101);
      chk(page_len == 60, "R2", "101 rejected", int'(page_len), 60);
      write_len(20);
      chk(page_len == 20, "R2", "20 accepted", int'(page_len), 20);
      chk(line_pos == 0, "R2", "position after load", int'(line_pos), 0);

      // Table walk: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         run_cmd(VEC[i][19:16], int'(VEC[i][15:8]), int'(VEC[i][7:1]),
                 VEC[i][0], 1'b0);
      end

      // R2: rejected write keeps position, accepted write clears it
      write_len(101);
      chk(page_len == 20, "R2", "101 rejected later", int'(page_len), 20);
      chk(line_pos == 1, "R2", "position kept on reject", int'(line_pos), 1);
      write_len(100);
      chk(page_len == 100, "R2", "100 accepted", int'(page_len), 100);
      chk(line_pos == 0, "R2", "position cleared on load", int'(line_pos), 0);

      // R9: full-page skip with go and page write arriving while busy
      run_cmd(4'b0001, 100, 0, 1'b1, 1'b1);
      chk(page_len == 100, "R9", "page length held", int'(page_len), 100);
      @(negedge clk);
      chk(busy == 1'b0, "R9", "no stray command", int'(busy), 0);

      // R5 after a long skip: plain print from top of page
      run_cmd(4'b0000, 1, 1, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule